// File: doc/BRIEF.md
# Integer Execute Unit with Compare-Set Operations

This block is the purely combinational integer execute stage of a 32-bit load/store RISC core. It takes a first operand from a register and a second operand from either a register or a 16-bit immediate. It applies one of seventeen functions and returns a 32-bit result together with a signed-overflow flag. The functions are:

- signed and unsigned add and subtract;
- bitwise AND, OR and XOR;
- a load-high function that places the immediate in the upper half of the word;
- logical and arithmetic shifts;
- six compare-and-set functions that write exactly 1 or 0.

The immediate is widened according to the function. It is sign-extended for signed arithmetic and signed comparisons. It is zero-extended for the bitwise, unsigned and unsigned-compare cases.

A separate input switches the six comparisons between signed and unsigned ordering. The shifter can be built as a plain behavioural operator or as an explicit logarithmic barrel. A parameter selects between the two, and both must behave identically.

Top module: `int_exec_unit`

## Requirements
- R1: `fn_i` (5 bits) selects the function: 0 add, 1 add-unsigned, 2 sub, 3 sub-unsigned, 4 AND, 5 OR, 6 XOR, 7 load-high, 8 shift-left-logical, 9 shift-right-logical, 10 shift-right-arithmetic, 11 less-than, 12 greater-than, 13 less-or-equal, 14 greater-or-equal, 15 equal, 16 not-equal.
- R2: With `use_imm_i`=0 the second operand is `rt_i`; with `use_imm_i`=1 it is `imm_i` widened to 32 bits and `rt_i` has no effect.
- R3: Codes 0 and 1 give `rs_i` plus operand B modulo 2^32. Codes 2 and 3 give `rs_i` minus operand B modulo 2^32.
- R4: `ovf_o` is 1 only for codes 0 and 2, when the two's-complement result does not fit in 32 bits. It is 0 for every other code, including the unsigned forms.
- R5: The immediate is sign-extended (bit 15 copied into bits 31:16) for codes 0 and 2, and for codes 11 to 16 when `ucmp_i`=0. It is zero-extended for codes 1, 3, 4, 5 and 6, and for codes 11 to 16 when `ucmp_i`=1.
- R6: Codes 4, 5 and 6 give the bitwise AND, OR and XOR of `rs_i` and operand B.
- R7: Code 7 gives `imm_i` in bits 31:16 and zeros in bits 15:0. `rs_i`, `rt_i` and `use_imm_i` have no effect.
- R8: Codes 8 and 9 shift `rs_i` left or right and fill the vacated bits with 0.
- R9: Code 10 shifts `rs_i` right and fills the vacated bits with bit 31 of `rs_i`.
- R10: The shift distance is bits 4:0 of operand B; bits 31:5 are ignored.
- R11: Codes 11 to 16 give exactly 1 when `rs_i` relates to operand B as named and 0 otherwise. When `ucmp_i`=0 both values are compared as two's-complement numbers.
- R12: With `ucmp_i`=1, codes 11 to 16 compare both values as unsigned numbers.
- R13: Codes 17 to 31 give a result of 0 and `ovf_o`=0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fn_i | input | 5 | Function code |
| use_imm_i | input | 1 | 1 selects the widened immediate as operand B |
| ucmp_i | input | 1 | 1 makes the six comparisons unsigned |
| rs_i | input | DATA_W (32) | First operand |
| rt_i | input | DATA_W (32) | Register second operand |
| imm_i | input | IMM_W (16) | Immediate field |
| result_o | output | DATA_W (32) | Function result |
| ovf_o | output | 1 | Signed overflow of add or sub |

## Verification
The bench builds two copies side by side with the default widths (DATA_W=32, IMM_W=16): one with SHIFT_IMPL=0 (behavioural shifter) and one with SHIFT_IMPL=1 (barrel shifter). Every expected item is compared against both copies. Directed items reach the overflow edges at 0x7FFFFFFF and 0x80000000, the shift distances 0, 31 and above 31, and the immediate-extension corners at 0xFFFF and 0x8000. A random sweep over all 32 function codes exercises the unused codes and the mix of signed and unsigned comparisons against a reference model.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

   typedef enum logic [4:0] {
      FN_ADD  = 5'd0,
      FN_ADDU = 5'd1,
      FN_SUB  = 5'd2,
      FN_SUBU = 5'd3,
      FN_AND  = 5'd4,
      FN_OR   = 5'd5,
      FN_XOR  = 5'd6,
      FN_LHI  = 5'd7,
      FN_SLL  = 5'd8,
      FN_SRL  = 5'd9,
      FN_SRA  = 5'd10,
      FN_LT   = 5'd11,
      FN_GT   = 5'd12,
      FN_LE   = 5'd13,
      FN_GE   = 5'd14,
      FN_EQ   = 5'd15,
      FN_NE   = 5'd16
   } fn_e;

   localparam int FN_W = 5;

   function automatic logic fn_is_cmp(input logic [FN_W-1:0] f);
      return (f >= FN_LT) && (f <= FN_NE);
   endfunction

   function automatic logic fn_is_shift(input logic [FN_W-1:0] f);
      return (f >= FN_SLL) && (f <= FN_SRA);
   endfunction

   // immediate widening policy: signed arithmetic and signed compares sign-extend
   function automatic logic fn_imm_sext(input logic [FN_W-1:0] f, input logic ucmp);
      return (f == FN_ADD) || (f == FN_SUB) || (fn_is_cmp(f) && !ucmp);
   endfunction

endpackage

// File: rtl/exec_opnd_sel.sv
module exec_opnd_sel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] rt_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   input  logic              sext_i,
   output logic [DATA_W-1:0] opb_o
);

   localparam int EXT_W = DATA_W - IMM_W;

   logic [EXT_W-1:0]  ext_bits;
   logic [DATA_W-1:0] imm_wide;

   assign ext_bits = {EXT_W{sext_i & imm_i[IMM_W-1]}};
   assign imm_wide = {ext_bits, imm_i};
   assign opb_o    = use_imm_i ? imm_wide : rt_i;

   always_comb begin
      if (use_imm_i && !sext_i) begin
         // R5
         zext_upper_chk: assert (opb_o[DATA_W-1:IMM_W] == '0)
            else $error("zero-extended immediate has upper bits set");
      end
   end

endmodule

// File: rtl/exec_addsub.sv
module exec_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              sovf_o
);

   logic [DATA_W-1:0] b_eff;

   assign b_eff  = sub_i ? ~b_i : b_i;
   assign sum_o  = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
   assign sovf_o = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
                   (sum_o[DATA_W-1] != a_i[DATA_W-1]);

endmodule

// File: rtl/exec_shift.sv
module exec_shift #(
   parameter int DATA_W     = 32,
   parameter int SHIFT_IMPL = 0,
   localparam int SHW       = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [SHW-1:0]    amt_i,
   input  logic              right_i,
   input  logic              arith_i,
   output logic [DATA_W-1:0] res_o
);

   generate
      if (SHIFT_IMPL == 0) begin : g_behav
         always_comb begin
            if (!right_i)
               res_o = val_i << amt_i;
            else if (arith_i)
               res_o = $unsigned($signed(val_i) >>> amt_i);
            else
               res_o = val_i >> amt_i;
         end
      end else begin : g_barrel
         logic [DATA_W-1:0] rev_in;
         logic [DATA_W-1:0] rev_out;
         logic [DATA_W-1:0] stage [0:SHW];
         logic              fill;

         for (genvar i = 0; i < DATA_W; i++) begin : g_rev
            assign rev_in[i]  = val_i[DATA_W-1-i];
            assign rev_out[i] = stage[SHW][DATA_W-1-i];
         end

         assign fill     = right_i & arith_i & val_i[DATA_W-1];
         assign stage[0] = right_i ? val_i : rev_in;

         for (genvar k = 0; k < SHW; k++) begin : g_stg
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt_i[k] ?
                                {{STEP{fill}}, stage[k][DATA_W-1:STEP]} : stage[k];
         end

         assign res_o = right_i ? stage[SHW] : rev_out;
      end
   endgenerate

   always_comb begin
      if (right_i && amt_i != '0) begin
         if (arith_i) begin
            // R9
            sra_sign_chk: assert (res_o[DATA_W-1] == val_i[DATA_W-1])
               else $error("arithmetic right shift lost the sign");
         end else begin
            // R8
            srl_fill_chk: assert (res_o[DATA_W-1] == 1'b0)
               else $error("logical right shift filled with one");
         end
      end
      if (!right_i && amt_i != '0) begin
         // R8
         sll_fill_chk: assert (res_o[0] == 1'b0)
            else $error("left shift filled with one");
      end
   end

endmodule

// File: rtl/exec_cmp.sv
module exec_cmp #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              unsigned_i,
   output logic              lt_o,
   output logic              eq_o,
   output logic              gt_o
);

   assign eq_o = (a_i == b_i);
   assign lt_o = unsigned_i ? (a_i < b_i) : ($signed(a_i) < $signed(b_i));
   assign gt_o = unsigned_i ? (a_i > b_i) : ($signed(a_i) > $signed(b_i));

   always_comb begin
      // R11 R12
      cmp_onehot_chk: assert ($onehot({lt_o, eq_o, gt_o}))
         else $error("comparator relations not exclusive");
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter int SHIFT_IMPL = 0
) (
   input  logic [FN_W-1:0]   fn_i,
   input  logic              use_imm_i,
   input  logic              ucmp_i,
   input  logic [DATA_W-1:0] rs_i,
   input  logic [DATA_W-1:0] rt_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] result_o,
   output logic              ovf_o
);

   localparam int SHW   = $clog2(DATA_W);
   localparam int LOW_W = DATA_W - IMM_W;

   generate
      if (DATA_W < 2 * IMM_W) begin : g_bad_width
         $error("DATA_W must hold at least two immediates");
      end
      if ((1 << SHW) != DATA_W) begin : g_bad_pow2
         $error("DATA_W must be a power of two");
      end
      if (SHIFT_IMPL < 0 || SHIFT_IMPL > 1) begin : g_bad_impl
         $error("SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   fn_e               fn;
   logic              sext;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] sum;
   logic              sovf;
   logic [DATA_W-1:0] shres;
   logic              lt, eq, gt;
   logic              cond;

   assign fn   = fn_e'(fn_i);
   assign sext = fn_imm_sext(fn_i, ucmp_i);

   exec_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
      .rt_i      (rt_i),
      .imm_i     (imm_i),
      .use_imm_i (use_imm_i),
      .sext_i    (sext),
      .opb_o     (opb)
   );

   exec_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i    (rs_i),
      .b_i    (opb),
      .sub_i  ((fn == FN_SUB) || (fn == FN_SUBU)),
      .sum_o  (sum),
      .sovf_o (sovf)
   );

   exec_shift #(.DATA_W(DATA_W), .SHIFT_IMPL(SHIFT_IMPL)) u_shift (
      .val_i   (rs_i),
      .amt_i   (opb[SHW-1:0]),
      .right_i (fn != FN_SLL),
      .arith_i (fn == FN_SRA),
      .res_o   (shres)
   );

   exec_cmp #(.DATA_W(DATA_W)) u_cmp (
      .a_i        (rs_i),
      .b_i        (opb),
      .unsigned_i (ucmp_i),
      .lt_o       (lt),
      .eq_o       (eq),
      .gt_o       (gt)
   );

   always_comb begin
      case (fn)
         FN_LT:   cond = lt;
         FN_GT:   cond = gt;
         FN_LE:   cond = lt | eq;
         FN_GE:   cond = gt | eq;
         FN_EQ:   cond = eq;
         FN_NE:   cond = !eq;
         default: cond = 1'b0;
      endcase
   end

   always_comb begin
      ovf_o = 1'b0;
      case (fn)
         FN_ADD, FN_SUB: begin
            result_o = sum;
            ovf_o    = sovf;
         end
         FN_ADDU, FN_SUBU:             result_o = sum;
         FN_AND:                       result_o = rs_i & opb;
         FN_OR:                        result_o = rs_i | opb;
         FN_XOR:                       result_o = rs_i ^ opb;
         FN_LHI:                       result_o = {imm_i, {LOW_W{1'b0}}};
         FN_SLL, FN_SRL, FN_SRA:       result_o = shres;
         FN_LT, FN_GT, FN_LE,
         FN_GE, FN_EQ, FN_NE:          result_o = {{(DATA_W-1){1'b0}}, cond};
         default:                      result_o = '0;
      endcase
   end

   always_comb begin
      if (fn != FN_ADD && fn != FN_SUB) begin
         // R4
         no_overflow_chk: assert (!ovf_o)
            else $error("overflow raised outside signed add/sub");
      end
      if (fn == FN_LHI) begin
         // R7
         lhi_low_zero_chk: assert (result_o[LOW_W-1:0] == '0)
            else $error("load-high left low bits set");
      end
      if (fn_is_cmp(fn_i)) begin
         // R11
         cmp_bool_chk: assert (result_o[DATA_W-1:1] == '0)
            else $error("compare result not 0 or 1");
      end
      if (fn_i > FN_NE) begin
         // R13
         unused_zero_chk: assert (result_o == '0 && !ovf_o)
            else $error("unused code produced output");
      end
   end

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

   localparam int DW = 32;
   localparam int IW = 16;

   typedef struct {
      logic [DW-1:0] res;
      logic          ovf;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    fn = '0;
   logic          ui = 1'b0;
   logic          uc = 1'b0;
   logic [DW-1:0] rs = '0;
   logic [DW-1:0] rt = '0;
   logic [IW-1:0] im = '0;
   logic [DW-1:0] res_a, res_b;
   logic          ovf_a, ovf_b;

   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   int_exec_unit #(.DATA_W(DW), .IMM_W(IW), .SHIFT_IMPL(0)) u_int_exec_unit (
      .fn_i(fn), .use_imm_i(ui), .ucmp_i(uc), .rs_i(rs), .rt_i(rt), .imm_i(im),
      .result_o(res_a), .ovf_o(ovf_a)
   );

   int_exec_unit #(.DATA_W(DW), .IMM_W(IW), .SHIFT_IMPL(1)) u_int_exec_unit_bar (
      .fn_i(fn), .use_imm_i(ui), .ucmp_i(uc), .rs_i(rs), .rt_i(rt), .imm_i(im),
      .result_o(res_b), .ovf_o(ovf_b)
   );

   // reference model built from the requirements
   function automatic logic [DW:0] ref_calc(input logic [4:0] f, input logic u_imm,
      input logic u_cmp, input logic [DW-1:0] a, input logic [DW-1:0] r,
      input logic [IW-1:0] i);
      logic          sx;
      logic [DW-1:0] b, o;
      logic          v;
      logic          slt, sgt, seq;
      sx = (f == 0) || (f == 2) || (f >= 11 && f <= 16 && !u_cmp);
      b  = u_imm ? (sx ? {{(DW-IW){i[IW-1]}}, i} : {{(DW-IW){1'b0}}, i}) : r;
      v  = 1'b0;
      seq = (a == b);
      slt = u_cmp ? (a < b) : ($signed(a) < $signed(b));
      sgt = u_cmp ? (a > b) : ($signed(a) > $signed(b));
      case (f)
         0: begin o = a + b; v = (a[DW-1] == b[DW-1]) && (o[DW-1] != a[DW-1]); end
         1: o = a + b;
         2: begin o = a - b; v = (a[DW-1] != b[DW-1]) && (o[DW-1] != a[DW-1]); end
         3: o = a - b;
         4: o = a & b;
         5: o = a | b;
         6: o = a ^ b;
         7: o = {i, {(DW-IW){1'b0}}};
         8: o = a << b[4:0];
         9: o = a >> b[4:0];
         10: o = $unsigned($signed(a) >>> b[4:0]);
         11: o = DW'(slt);
         12: o = DW'(sgt);
         13: o = DW'(slt | seq);
         14: o = DW'(sgt | seq);
         15: o = DW'(seq);
         16: o = DW'(!seq);
         default: o = '0;
      endcase
      return {v, o};
   endfunction

   function automatic string req_of(input logic [4:0] f);
      if (f <= 3)  return "R3";
      if (f <= 6)  return "R6";
      if (f == 7)  return "R7";
      if (f <= 9)  return "R8";
      if (f == 10) return "R9";
      if (f <= 16) return "R11";
      return "R13";
   endfunction

   task automatic drive(input logic [4:0] f, input logic u_imm, input logic u_cmp,
      input logic [DW-1:0] a, input logic [DW-1:0] r, input logic [IW-1:0] i,
      input logic [DW-1:0] er, input logic eo, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      fn = f; ui = u_imm; uc = u_cmp; rs = a; rt = r; im = i;
      e.res = er; e.ovf = eo; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic drive_ref(input logic [4:0] f, input logic u_imm, input logic u_cmp,
      input logic [DW-1:0] a, input logic [DW-1:0] r, input logic [IW-1:0] i);
      logic [DW:0] x;
      x = ref_calc(f, u_imm, u_cmp, a, r, i);
      drive(f, u_imm, u_cmp, a, r, i, x[DW-1:0], x[DW], {req_of(f), " random"});
   endtask

   // monitor: pops one expected item per driven vector
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (res_a !== e.res || ovf_a !== e.ovf) begin
            fails++;
            $display("FAIL %s behav: result %h ovf %b expected %h ovf %b",
                     e.tag, res_a, ovf_a, e.res, e.ovf);
         end
         checks++;
         if (res_b !== e.res || ovf_b !== e.ovf) begin
            fails++;
            $display("FAIL %s barrel: result %h ovf %b expected %h ovf %b",
                     e.tag, res_b, ovf_b, e.res, e.ovf);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs select add of zeros
      drive(5'd0, 0, 0, 32'h0, 32'h0, 16'h0, 32'h0, 0, "R1 idle zero");
      // R3 R4 signed add/sub
      drive(5'd0, 0, 0, 32'd5, 32'd7, 16'h0, 32'd12, 0, "R3 add");
      drive(5'd0, 0, 0, 32'h7FFFFFFF, 32'd1, 16'h0, 32'h80000000, 1, "R4 add ovf");
      drive(5'd2, 0, 0, 32'h80000000, 32'd1, 16'h0, 32'h7FFFFFFF, 1, "R4 sub ovf");
      drive(5'd2, 1, 0, 32'd2, 32'hDEAD, 16'd2, 32'd0, 0, "R3 subi");
      // R5 immediate extension
      drive(5'd0, 1, 0, 32'd10, 32'h0, 16'hFFFF, 32'd9, 0, "R5 addi sext");
      drive(5'd1, 1, 0, 32'd10, 32'h0, 16'hFFFF, 32'h00010009, 0, "R5 addui zext");
      drive(5'd1, 0, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 32'h0, 0, "R4 addu no ovf");
      drive(5'd3, 0, 0, 32'h0, 32'd1, 16'h0, 32'hFFFFFFFF, 0, "R4 subu no ovf");
      drive(5'd3, 0, 0, 32'h80000000, 32'd1, 16'h0, 32'h7FFFFFFF, 0, "R4 subu edge");
      // R2 rt ignored with immediate
      drive(5'd5, 1, 0, 32'h0, 32'hFFFFFFFF, 16'h00F0, 32'h000000F0, 0, "R2 imm select");
      // R6 logic
      drive(5'd4, 1, 0, 32'hFFFFFFFF, 32'h0, 16'h8000, 32'h00008000, 0, "R6 andi zext");
      drive(5'd5, 0, 0, 32'hF0F00000, 32'h00000F0F, 16'h0, 32'hF0F00F0F, 0, "R6 or");
      drive(5'd6, 1, 0, 32'h12345678, 32'h0, 16'hFFFF, 32'h1234A987, 0, "R6 xori");
      // R7 load-high
      drive(5'd7, 1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0042, 32'h00420000, 0, "R7 lhi");
      drive(5'd7, 0, 1, 32'h12345678, 32'h1, 16'hABCD, 32'hABCD0000, 0, "R7 lhi reg");
      // R8 R9 R10 shifts
      drive(5'd8, 0, 0, 32'd1, 32'd31, 16'h0, 32'h80000000, 0, "R8 sll 31");
      drive(5'd8, 0, 0, 32'd1, 32'd35, 16'h0, 32'd8, 0, "R10 sll wrap");
      drive(5'd8, 1, 0, 32'hA5A5A5A5, 32'h0, 16'hFFE0, 32'hA5A5A5A5, 0, "R10 slli zero");
      drive(5'd9, 0, 0, 32'h80000000, 32'd4, 16'h0, 32'h08000000, 0, "R8 srl");
      drive(5'd10, 0, 0, 32'h80000000, 32'd4, 16'h0, 32'hF8000000, 0, "R9 sra neg");
      drive(5'd10, 1, 0, 32'hFFFFFFF0, 32'h0, 16'h0002, 32'hFFFFFFFC, 0, "R9 srai");
      drive(5'd10, 0, 0, 32'h40000000, 32'd30, 16'h0, 32'd1, 0, "R9 sra pos");
      // R11 signed comparisons
      drive(5'd11, 0, 0, 32'hFFFFFFFF, 32'd1, 16'h0, 32'd1, 0, "R11 lt signed");
      drive(5'd12, 0, 0, 32'd5, 32'd3, 16'h0, 32'd1, 0, "R11 gt");
      drive(5'd13, 0, 0, 32'd3, 32'd3, 16'h0, 32'd1, 0, "R11 le eq");
      drive(5'd14, 0, 0, 32'd2, 32'd3, 16'h0, 32'd0, 0, "R11 ge false");
      drive(5'd15, 0, 0, 32'h1234, 32'h1234, 16'h0, 32'd1, 0, "R11 eq");
      drive(5'd16, 1, 0, 32'd7, 32'h0, 16'h0007, 32'd0, 0, "R11 nei equal");
      drive(5'd16, 1, 0, 32'd8, 32'h0, 16'h0007, 32'd1, 0, "R11 nei differ");
      drive(5'd11, 1, 0, 32'd0, 32'h0, 16'hFFFF, 32'd0, 0, "R5 lti sext");
      // R12 unsigned comparisons
      drive(5'd11, 0, 1, 32'hFFFFFFFF, 32'd1, 16'h0, 32'd0, 0, "R12 lt unsigned");
      drive(5'd11, 1, 1, 32'd0, 32'h0, 16'hFFFF, 32'd1, 0, "R12 lti zext");
      drive(5'd12, 0, 1, 32'h80000000, 32'h7FFFFFFF, 16'h0, 32'd1, 0, "R12 gt unsigned");
      // R13 unused codes
      drive(5'd17, 0, 0, 32'h7FFFFFFF, 32'd1, 16'hFFFF, 32'd0, 0, "R13 code 17");
      drive(5'd31, 1, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 32'd0, 0, "R13 code 31");
      // R1 random sweep over every code
      for (int n = 0; n < 400; n++) begin
         logic [DW-1:0] a, r;
         a = $urandom();
         r = $urandom();
         if (n % 7 == 0) a = 32'h7FFFFFFF;
         if (n % 11 == 0) r = a;
         if (n % 13 == 0) a = 32'h80000000;
         drive_ref(5'($urandom_range(0, 31)), 1'($urandom()), 1'($urandom()),
                   a, r, 16'($urandom()));
      end
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule